// File: doc/BRIEF.md
# Frame Base Address Latch

This block keeps the start address of the frame buffer that a display controller scans. Software may write a new base address at any moment. The value waits in a pending register and moves into the active scan address only on the first frame-start strobe from the timing generator that follows the write. A frame that is already being scanned therefore never changes its base address partway through.

Each such swap sets a "base loaded" status flag. A small four-register interface gives software an enable mask, a masked status view and a write-one-to-clear register. One registered interrupt line reports any status bit that is both set and enabled. Memory fetch and pixel handling belong to other blocks. This block only supplies the address that is valid for the current frame.

Top module: `fb_base_latch`

## Requirements
- R1: After reset the pending address, active address, enable mask, status and `irq_o` are all zero. Reads of selector 0, 1 and 2 return zero.
- R2: A write to selector 0 stores the data in the pending register with bits [1:0] forced to zero. The stored value reads back at selector 0. `active_base_o` does not change until a frame-start strobe arrives.
- R3: On the first `frame_start_i` cycle after a base write, the pending address is copied to `active_base_o`. Later strobes with no new write change neither the address nor the status.
- R4: A base write in the same cycle as `frame_start_i` is not loaded by that strobe. It is loaded by the next strobe.
- R5: The status bit 0 ("base loaded") is set in the cycle of the copy, even while its enable is zero.
- R6: A read at selector 2 returns the status ANDed with the enable mask held at selector 1. Bit 0 is the only source.
- R7: A write to selector 3 clears each status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R8: If a copy and a clear of the same bit happen in the same cycle, the bit ends up set.
- R9: `irq_o` is a register that, one cycle later, carries the OR of all masked status bits.
- R10: Writing zero to selector 1 masks every source. The selector 2 read becomes zero and `irq_o` falls one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register selector: 0 base, 1 enable, 2 masked status, 3 clear |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_sel` |
| frame_start_i | input | 1 | One-cycle frame boundary strobe |
| active_base_o | output | DATA_W | Base address valid for the current frame |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The hardest cases to reach are the same-cycle collisions. One is a frame strobe arriving together with a base write. The other is a frame strobe arriving together with a clear of the flag it sets. Each collision is resolved by a single priority choice that ordinary register traffic never exercises. The bench has a task that drives the strobe and the bus write together in one cycle. It then checks which value wins, both on the active address and through the masked status read.

// File: rtl/fb_base_pkg.sv
package fb_base_pkg;
  typedef enum logic [1:0] {
    SEL_BASE  = 2'd0,
    SEL_IEN   = 2'd1,
    SEL_MSTAT = 2'd2,
    SEL_ICLR  = 2'd3
  } reg_sel_e;

  localparam int IRQ_W        = 1;
  localparam int SRC_BASE_LD  = 0;
endpackage

// File: rtl/fb_reg_decode.sv
module fb_reg_decode
  import fb_base_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              bus_wr,
  input  logic [1:0]        bus_sel,
  input  logic [DATA_W-1:0] pending_i,
  input  logic [IRQ_W-1:0]  ien_i,
  input  logic [IRQ_W-1:0]  mstat_i,
  output logic              base_wr_o,
  output logic              ien_wr_o,
  output logic              iclr_wr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int PAD_W = DATA_W - IRQ_W;

  assign base_wr_o = bus_wr && (bus_sel == SEL_BASE);
  assign ien_wr_o  = bus_wr && (bus_sel == SEL_IEN);
  assign iclr_wr_o = bus_wr && (bus_sel == SEL_ICLR);

  always_comb begin
    case (bus_sel)
      SEL_BASE:  rdata_o = pending_i;
      SEL_IEN:   rdata_o = {{PAD_W{1'b0}}, ien_i};
      SEL_MSTAT: rdata_o = {{PAD_W{1'b0}}, mstat_i};
      default:   rdata_o = '0;
    endcase
  end

  always_comb begin
    assert ($countones({base_wr_o, ien_wr_o, iclr_wr_o}) <= 1)
      else $error("decode strobes overlap (R2 R7 R10)");
  end
endmodule

// File: rtl/fb_base_swap.sv
module fb_base_swap #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              frame_start_i,
  output logic [DATA_W-1:0] pending_o,
  output logic [DATA_W-1:0] active_o,
  output logic              swap_o
);
  localparam logic [DATA_W-1:0] ALIGN_MASK = ~{{(DATA_W-2){1'b0}}, 2'b11};

  function automatic logic [DATA_W-1:0] word_align(input logic [DATA_W-1:0] a);
    return a & ALIGN_MASK;
  endfunction

  logic pend_valid_q;

  // copy uses only state that existed before this cycle's write
  assign swap_o = frame_start_i && pend_valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_o    <= '0;
      active_o     <= '0;
      pend_valid_q <= 1'b0;
    end else begin
      if (swap_o) active_o <= pending_o;
      if (base_wr_i) begin
        pending_o    <= word_align(wdata_i);
        pend_valid_q <= 1'b1;
      end else if (swap_o) begin
        pend_valid_q <= 1'b0;
      end
    end
  end

  assert_hold_between_frames_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_o |=> $stable(active_o));
  assert_copy_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_o && !base_wr_i) |=> (active_o == pending_o));
  assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr_i |=> (pending_o[1:0] == 2'b00));
  assert_strobe_with_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (base_wr_i && frame_start_i) |=> pend_valid_q);
endmodule

// File: rtl/fb_irq_ctrl.sv
module fb_irq_ctrl
  import fb_base_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ien_wr_i,
  input  logic             iclr_wr_i,
  input  logic [IRQ_W-1:0] wdata_i,
  input  logic [IRQ_W-1:0] set_i,
  output logic [IRQ_W-1:0] ien_o,
  output logic [IRQ_W-1:0] mstat_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] raw_q;
  logic [IRQ_W-1:0] clr_mask;
  logic             any_masked;

  assign clr_mask   = iclr_wr_i ? wdata_i : '0;
  assign mstat_o    = raw_q & ien_o;
  assign any_masked = |mstat_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      ien_o <= '0;
      irq_o <= 1'b0;
    end else begin
      raw_q <= (raw_q & ~clr_mask) | set_i;   // set has priority
      if (ien_wr_i) ien_o <= wdata_i;
      irq_o <= any_masked;
    end
  end

  assert_set_on_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_i[SRC_BASE_LD] |=> raw_q[SRC_BASE_LD]);
  assert_clear_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask[SRC_BASE_LD] && !set_i[SRC_BASE_LD]) |=> !raw_q[SRC_BASE_LD]);
  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    any_masked |=> irq_o);
  assert_mask_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_wr_i && (wdata_i == '0)) |=> ##1 !irq_o);
endmodule

// File: rtl/fb_base_latch.sv
module fb_base_latch
  import fb_base_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              frame_start_i,
  output logic [DATA_W-1:0] active_base_o,
  output logic              irq_o
);
  logic              base_wr, ien_wr, iclr_wr, swap_evt;
  logic [DATA_W-1:0] pending;
  logic [IRQ_W-1:0]  ien, mstat, set_vec;

  always_comb begin
    set_vec              = '0;
    set_vec[SRC_BASE_LD] = swap_evt;
  end

  fb_reg_decode #(.DATA_W(DATA_W)) u_dec (
    .bus_wr(bus_wr), .bus_sel(bus_sel), .pending_i(pending),
    .ien_i(ien), .mstat_i(mstat), .base_wr_o(base_wr),
    .ien_wr_o(ien_wr), .iclr_wr_o(iclr_wr), .rdata_o(bus_rdata));

  fb_base_swap #(.DATA_W(DATA_W)) u_swap (
    .clk(clk), .rst_n(rst_n), .base_wr_i(base_wr), .wdata_i(bus_wdata),
    .frame_start_i(frame_start_i), .pending_o(pending),
    .active_o(active_base_o), .swap_o(swap_evt));

  fb_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .ien_wr_i(ien_wr), .iclr_wr_i(iclr_wr),
    .wdata_i(bus_wdata[IRQ_W-1:0]), .set_i(set_vec), .ien_o(ien),
    .mstat_o(mstat), .irq_o(irq_o));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_evt && iclr_wr && bus_wdata[SRC_BASE_LD]) |=> (mstat[SRC_BASE_LD] == ien[SRC_BASE_LD]));
endmodule

// File: tb/sim_fb_base_latch.sv
module sim_fb_base_latch;
  localparam int W = 32;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, frame_start_i = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [W-1:0] bus_wdata = '0, bus_rdata, active_base_o;
  logic irq_o;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  fb_base_latch #(.DATA_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frame_start_i(frame_start_i), .active_base_o(active_base_o), .irq_o(irq_o));

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic read_chk(input string req, input logic [1:0] sel, input logic [W-1:0] exp);
    bus_sel = sel; #1;
    check(req, bus_rdata, exp);
  endtask

  // drive one cycle: optional write plus optional strobe, return at negedge
  task automatic cyc(input logic wr, input logic [1:0] sel, input logic [W-1:0] d, input logic fs);
    bus_wr = wr; bus_sel = sel; bus_wdata = d; frame_start_i = fs;
    @(negedge clk);
    bus_wr = 1'b0; frame_start_i = 1'b0;
  endtask

  task automatic t_reset;
    read_chk("R1", 2'd0, 0); read_chk("R1", 2'd1, 0); read_chk("R1", 2'd2, 0);
    check("R1", active_base_o, 0); check("R1", {31'd0, irq_o}, 0);
  endtask

  task automatic t_write_hold;
    cyc(1, 2'd0, 32'h1234_5677, 0);
    read_chk("R2", 2'd0, 32'h1234_5674);
    repeat (3) @(negedge clk);
    check("R2", active_base_o, 0);
  endtask

  task automatic t_swap_masked;
    cyc(0, 2'd0, 0, 1);
    check("R3", active_base_o, 32'h1234_5674);
    read_chk("R6", 2'd2, 0);
    check("R9", {31'd0, irq_o}, 0);
    cyc(1, 2'd1, 1, 0);
    read_chk("R5", 2'd2, 1);
    read_chk("R6", 2'd1, 1);
    check("R9", {31'd0, irq_o}, 0);
    @(negedge clk);
    check("R9", {31'd0, irq_o}, 1);
  endtask

  task automatic t_clear;
    cyc(1, 2'd3, 0, 0);
    read_chk("R7", 2'd2, 1);
    cyc(1, 2'd3, 1, 0);
    read_chk("R7", 2'd2, 0);
    @(negedge clk);
    check("R9", {31'd0, irq_o}, 0);
    cyc(0, 2'd0, 0, 1);
    read_chk("R3", 2'd2, 0);
    check("R3", active_base_o, 32'h1234_5674);
  endtask

  task automatic t_write_with_strobe;
    cyc(1, 2'd0, 32'h0000_00A3, 1);
    check("R4", active_base_o, 32'h1234_5674);
    read_chk("R4", 2'd2, 0);
    cyc(0, 2'd0, 0, 1);
    check("R4", active_base_o, 32'h0000_00A0);
    read_chk("R4", 2'd2, 1);
    cyc(1, 2'd3, 1, 0);
  endtask

  task automatic t_set_beats_clear;
    cyc(1, 2'd0, 32'hBEEF_0000, 0);
    cyc(1, 2'd3, 1, 1);
    read_chk("R8", 2'd2, 1);
    check("R8", active_base_o, 32'hBEEF_0000);
  endtask

  task automatic t_mask_all;
    @(negedge clk);
    check("R9", {31'd0, irq_o}, 1);
    cyc(1, 2'd1, 0, 0);
    read_chk("R10", 2'd2, 0);
    check("R10", {31'd0, irq_o}, 1);
    @(negedge clk);
    check("R10", {31'd0, irq_o}, 0);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_write_hold;
    t_swap_masked;
    t_clear;
    t_write_with_strobe;
    t_set_beats_clear;
    t_mask_all;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule